// File: doc/BRIEF.md
# Clock Source Readiness Monitor

This block keeps one ready flag for each of three clock sources: a main oscillator, a sub oscillator and a PLL fed from the main oscillator. A flag at 1 means the source runs and may be used. A flag at 0 means the source is switched off or is still waiting out its stabilization time. Each source has its own stabilization counter. The flag rises when that counter reaches the length selected for the source.

Software supplies an enable for each source. It also writes a stabilization length code for each oscillator. The PLL always waits a fixed length, and it starts counting only after the main oscillator reports ready. Six separate reset-cause strobes come in from the reset logic, and each cause clears only the flags it is meant to clear. A source that drives system clock 1 or 2 keeps running when software removes its enable. For the main oscillator this also applies when the PLL derived from it drives a system clock. The flags also appear as a 16-bit status word.

Top module: `clk_ready_monitor`

## Requirements
- R1: While `rst_n` is low at a clock edge, all three ready flags and the whole status word become 0, and both length codes return to their defaults.
- R2: The main flag rises exactly 2^(MAIN_BASE-SHRINK+code) clock edges after the main source becomes effectively enabled, where code is the 3-bit main length code (0..7).
- R3: The sub flag rises exactly 2^(SUB_BASE-SHRINK+code) clock edges after the sub source becomes effectively enabled, where code is the 2-bit sub length code (0..3).
- R4: The PLL flag rises exactly 2^(PLL_EXP-SHRINK) edges after both `pll_en` is high and the main flag is 1. While the main flag is 0, the PLL flag stays 0.
- R5: When a source is not effectively enabled, its flag goes to 0 one edge later and its counter stays at zero. When the source is enabled again, the full wait starts over.
- R6: A power-on, external or main-clock-stop strobe clears the main flag. A sub-clock-stop, software or watchdog strobe leaves a main flag that is already 1 at 1.
- R7: A power-on, external or sub-clock-stop strobe clears the sub flag. A main-clock-stop, software or watchdog strobe leaves a sub flag that is already 1 at 1.
- R8: Every one of the six reset strobes clears the PLL flag.
- R9: Every reset strobe sets the main code to 3'b111 and the sub code to 2'b11. A source still in its wait when a strobe arrives ends with its flag at 0 and restarts counting from zero, so it sees the default length.
- R10: While a source's flag is 1 and that source drives a system clock (`main_sys_use` or `pll_sys_use` for the main oscillator, `sub_sys_use` for the sub oscillator, `pll_sys_use` for the PLL), clearing its enable leaves the flag at 1.
- R11: `ready_status` carries the main flag at bit 13, the PLL flag at bit 14 and the sub flag at bit 15. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock for all counters |
| rst_n | input | 1 | Synchronous active-low block reset |
| por_rst_evt | input | 1 | Power-on reset cause strobe |
| ext_rst_evt | input | 1 | External reset cause strobe |
| mclk_stop_evt | input | 1 | Main-clock-stop reset cause strobe |
| sclk_stop_evt | input | 1 | Sub-clock-stop reset cause strobe |
| sw_rst_evt | input | 1 | Software reset cause strobe |
| wdog_rst_evt | input | 1 | Watchdog reset cause strobe |
| main_osc_en | input | 1 | Software enable, main oscillator |
| sub_osc_en | input | 1 | Software enable, sub oscillator |
| pll_en | input | 1 | Software enable, PLL |
| stab_sel_we | input | 1 | Write strobe for both length codes |
| main_stab_sel | input | 3 | New main length code |
| sub_stab_sel | input | 2 | New sub length code |
| main_sys_use | input | 1 | Main oscillator drives system clock 1 or 2 |
| sub_sys_use | input | 1 | Sub oscillator drives system clock 1 or 2 |
| pll_sys_use | input | 1 | PLL drives system clock 1 or 2 |
| main_ready | output | 1 | Main oscillator ready flag |
| pll_ready | output | 1 | PLL ready flag |
| sub_ready | output | 1 | Sub oscillator ready flag |
| ready_status | output | 16 | Status word holding the three flags |

## Verification
The assertions check on every cycle the rules that depend on cause and state. They cover which strobe clears which flag, that a ready main flag survives the strobes it must ignore, that the flags hold while a source is in use, that a disabled source drops its flag, and that the PLL flag rises only after the main flag was 1. The exact wait lengths can only be shown by the bench's scenarios. These are each main and sub length code, the fixed PLL wait, and a restart at the default length after a strobe in mid-wait. The bench also covers the keep-alive path, where a PLL in use holds the main oscillator.

// File: rtl/crm_pkg.sv
// Package: shared constants and types for the clock readiness monitor.
// Assumes all reset-cause strobes are synchronous to the monitor clock.
package crm_pkg;

    localparam logic [2:0] MAIN_SEL_DEFAULT = 3'b111;
    localparam logic [1:0] SUB_SEL_DEFAULT  = 2'b11;

    // One bit per reset cause, as delivered by the reset logic.
    typedef struct packed {
        logic por;
        logic ext;
        logic mstop;
        logic sstop;
        logic sw;
        logic wdog;
    } rst_cause_t;

    // True when any reset cause is active.
    function automatic logic any_cause(input rst_cause_t c);
        return c.por | c.ext | c.mstop | c.sstop | c.sw | c.wdog;
    endfunction

endpackage

// File: rtl/crm_sel_regs.sv
// Module: holds the main and sub stabilization length codes.
// Assumes: a reset cause has priority over a software write in the same cycle.
module crm_sel_regs
    import crm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       any_rst,
    input  logic       we,
    input  logic [2:0] main_in,
    input  logic [1:0] sub_in,
    output logic [2:0] main_sel,
    output logic [1:0] sub_sel
);

    // Load the defaults on any reset, otherwise take software writes.
    always_ff @(posedge clk) begin
        if (!rst_n || any_rst) begin
            main_sel <= MAIN_SEL_DEFAULT;
            sub_sel  <= SUB_SEL_DEFAULT;
        end else if (we) begin
            main_sel <= main_in;
            sub_sel  <= sub_in;
        end
    end

endmodule

// File: rtl/crm_stab_unit.sv
// Module: one stabilization counter and its ready flag.
// Assumes: term is the count minus one. It may change mid-wait; a counter
// already past the new terminal value finishes at once.
module crm_stab_unit #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,      // effective enable
    input  logic          clr,      // cause that clears this flag
    input  logic          restart,  // any reset cause
    input  logic [CW-1:0] term,
    output logic          rdy
);

    logic [CW-1:0] cnt;

    // Count while running; set the flag at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || clr || (restart && !rdy)) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (!run) begin
            cnt <= '0;
            rdy <= 1'b0;
        end else if (!rdy) begin
            if (cnt >= term) begin
                rdy <= 1'b1;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end

endmodule

// File: rtl/clk_ready_monitor.sv
// Module: readiness monitor for the main oscillator, sub oscillator and PLL.
// Assumes: single reference clock; SHRINK shortens every wait by 2^SHRINK
// for fast test runs, and SHRINK must stay below PLL_EXP.
module clk_ready_monitor
    import crm_pkg::*;
#(
    parameter int MAIN_BASE = 11,
    parameter int SUB_BASE  = 13,
    parameter int PLL_EXP   = 10,
    parameter int SHRINK    = 0
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        por_rst_evt,
    input  logic        ext_rst_evt,
    input  logic        mclk_stop_evt,
    input  logic        sclk_stop_evt,
    input  logic        sw_rst_evt,
    input  logic        wdog_rst_evt,
    input  logic        main_osc_en,
    input  logic        sub_osc_en,
    input  logic        pll_en,
    input  logic        stab_sel_we,
    input  logic [2:0]  main_stab_sel,
    input  logic [1:0]  sub_stab_sel,
    input  logic        main_sys_use,
    input  logic        sub_sys_use,
    input  logic        pll_sys_use,
    output logic        main_ready,
    output logic        pll_ready,
    output logic        sub_ready,
    output logic [15:0] ready_status
);

    localparam int MCW = MAIN_BASE + 7 - SHRINK;
    localparam int SCW = SUB_BASE + 3 - SHRINK;
    localparam int PCW = PLL_EXP - SHRINK;
    localparam logic [63:0] ONE = 64'd1;

    rst_cause_t   cause;
    logic         any_rst;
    logic [2:0]   main_sel;
    logic [1:0]   sub_sel;
    logic [MCW-1:0] main_term;
    logic [SCW-1:0] sub_term;
    logic [PCW-1:0] pll_term;
    logic         main_run, sub_run, pll_run;

    // Gather the cause strobes.
    always_comb begin
        cause = '{por: por_rst_evt, ext: ext_rst_evt, mstop: mclk_stop_evt,
                  sstop: sclk_stop_evt, sw: sw_rst_evt, wdog: wdog_rst_evt};
        any_rst = any_cause(cause);
    end

    crm_sel_regs u_sel (
        .clk      (clk),
        .rst_n    (rst_n),
        .any_rst  (any_rst),
        .we       (stab_sel_we),
        .main_in  (main_stab_sel),
        .sub_in   (sub_stab_sel),
        .main_sel (main_sel),
        .sub_sel  (sub_sel)
    );

    // Turn the length codes into terminal counts (length minus one).
    always_comb begin
        main_term = MCW'((ONE << (MAIN_BASE - SHRINK + int'(main_sel))) - ONE);
        sub_term  = SCW'((ONE << (SUB_BASE - SHRINK + int'(sub_sel))) - ONE);
        pll_term  = PCW'((ONE << PLL_EXP - SHRINK) - ONE);
    end

    // Effective enables: software enable, or kept alive while in use.
    always_comb begin
        main_run = main_osc_en | ((main_sys_use | pll_sys_use) & main_ready);
        sub_run  = sub_osc_en | (sub_sys_use & sub_ready);
        pll_run  = (pll_en | (pll_sys_use & pll_ready)) & main_ready;
    end

    crm_stab_unit #(.CW(MCW)) u_main (
        .clk (clk), .rst_n (rst_n), .run (main_run),
        .clr (cause.por | cause.ext | cause.mstop),
        .restart (any_rst), .term (main_term), .rdy (main_ready)
    );

    crm_stab_unit #(.CW(SCW)) u_sub (
        .clk (clk), .rst_n (rst_n), .run (sub_run),
        .clr (cause.por | cause.ext | cause.sstop),
        .restart (any_rst), .term (sub_term), .rdy (sub_ready)
    );

    crm_stab_unit #(.CW(PCW)) u_pll (
        .clk (clk), .rst_n (rst_n), .run (pll_run),
        .clr (any_rst),
        .restart (any_rst), .term (pll_term), .rdy (pll_ready)
    );

    // Place the flags in the status word.
    always_comb begin
        ready_status     = '0;
        ready_status[13] = main_ready;
        ready_status[14] = pll_ready;
        ready_status[15] = sub_ready;
    end

endmodule

// File: rtl/crm_checks.sv
// Module: cycle-level property checks for clk_ready_monitor, attached by bind.
// Assumes: all inputs are synchronous to clk.
module crm_checks (
    input logic        clk,
    input logic        rst_n,
    input logic        por_rst_evt,
    input logic        ext_rst_evt,
    input logic        mclk_stop_evt,
    input logic        sclk_stop_evt,
    input logic        sw_rst_evt,
    input logic        wdog_rst_evt,
    input logic        main_osc_en,
    input logic        sub_osc_en,
    input logic        main_sys_use,
    input logic        sub_sys_use,
    input logic        pll_sys_use,
    input logic        main_ready,
    input logic        pll_ready,
    input logic        sub_ready,
    input logic [15:0] ready_status
);

    logic main_clr, sub_clr, any_rst, soft_causes;

    // Group the causes by the flags they clear.
    always_comb begin
        main_clr    = por_rst_evt | ext_rst_evt | mclk_stop_evt;
        sub_clr     = por_rst_evt | ext_rst_evt | sclk_stop_evt;
        soft_causes = sw_rst_evt | wdog_rst_evt;
        any_rst     = main_clr | sub_clr | soft_causes;
    end

    p_main_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        main_clr |=> !main_ready);

    p_main_survive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ready && main_osc_en && !main_clr && (sclk_stop_evt || soft_causes)) |=> main_ready);

    p_sub_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sub_clr |=> !sub_ready);

    p_sub_survive_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_ready && sub_osc_en && !sub_clr && (mclk_stop_evt || soft_causes)) |=> sub_ready);

    p_pll_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_rst |=> !pll_ready);

    p_pll_after_main_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pll_ready) |-> $past(main_ready));

    p_main_needs_en_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(main_ready) |-> $past(main_osc_en));

    p_sub_needs_en_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sub_ready) |-> $past(sub_osc_en));

    p_main_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!main_osc_en && !main_sys_use && !pll_sys_use) |=> !main_ready);

    p_main_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (main_ready && main_sys_use && !main_clr) |=> main_ready);

    p_sub_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_ready && sub_sys_use && !sub_clr) |=> sub_ready);

    p_status_spare_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ready_status[12:0]) == 0);

endmodule

bind clk_ready_monitor crm_checks u_crm_checks (
    .clk (clk), .rst_n (rst_n),
    .por_rst_evt (por_rst_evt), .ext_rst_evt (ext_rst_evt),
    .mclk_stop_evt (mclk_stop_evt), .sclk_stop_evt (sclk_stop_evt),
    .sw_rst_evt (sw_rst_evt), .wdog_rst_evt (wdog_rst_evt),
    .main_osc_en (main_osc_en), .sub_osc_en (sub_osc_en),
    .main_sys_use (main_sys_use), .sub_sys_use (sub_sys_use),
    .pll_sys_use (pll_sys_use),
    .main_ready (main_ready), .pll_ready (pll_ready), .sub_ready (sub_ready),
    .ready_status (ready_status)
);

// File: tb/clk_ready_monitor_test.sv
// Bench: table of length codes and expected waits, then directed cases.
module clk_ready_monitor_test;

    localparam int CLK_PERIOD = 10;
    localparam int SHRINK     = 8;   // main 2^(3+c), sub 2^(5+c), PLL 4

    localparam int NV = 4;
    localparam int V_MCODE [NV] = '{0, 2, 5, 7};
    localparam int V_SCODE [NV] = '{0, 1, 2, 3};
    localparam int V_MWAIT [NV] = '{8, 32, 256, 1024};
    localparam int V_SWAIT [NV] = '{32, 64, 128, 256};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic por_rst_evt = 0, ext_rst_evt = 0, mclk_stop_evt = 0;
    logic sclk_stop_evt = 0, sw_rst_evt = 0, wdog_rst_evt = 0;
    logic main_osc_en = 0, sub_osc_en = 0, pll_en = 0;
    logic stab_sel_we = 0;
    logic [2:0] main_stab_sel = '0;
    logic [1:0] sub_stab_sel = '0;
    logic main_sys_use = 0, sub_sys_use = 0, pll_sys_use = 0;
    logic main_ready, pll_ready, sub_ready;
    logic [15:0] ready_status;

    int n_tests = 0;
    int n_fail  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clk_ready_monitor #(.SHRINK(SHRINK)) uut (.*);

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Count edges until a flag (0 main, 1 sub, 2 PLL) reads 1; -1 on timeout.
    task automatic wait_flag(input int which, input int maxc, output int n);
        n = 0;
        forever begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if ((which == 0 && main_ready) || (which == 1 && sub_ready) ||
                (which == 2 && pll_ready)) break;
            if (n >= maxc) begin n = -1; break; end
        end
    endtask

    task automatic write_sel(input int m, input int s);
        @(negedge clk);
        main_stab_sel = 3'(m);
        sub_stab_sel  = 2'(s);
        stab_sel_we   = 1'b1;
        @(negedge clk);
        stab_sel_we   = 1'b0;
    endtask

    initial begin
        int nm, ns, np;
        // R1: block reset clears everything.
        cycles(3);
        check("R1 main", main_ready, 0);
        check("R1 pll", pll_ready, 0);
        check("R1 sub", sub_ready, 0);
        check("R11 status at reset", ready_status, 0);
        rst_n = 1'b1;
        cycles(2);

        // Table walk, R2 and R3: wait length per code.
        for (int i = 0; i < NV; i++) begin
            main_osc_en = 0; sub_osc_en = 0;
            cycles(2);
            write_sel(V_MCODE[i], V_SCODE[i]);
            main_osc_en = 1; sub_osc_en = 1;
            nm = -1; ns = -1;
            for (int c = 1; c <= 1100; c++) begin
                @(posedge clk);
                @(negedge clk);
                if (nm < 0 && main_ready) nm = c;
                if (ns < 0 && sub_ready) ns = c;
                if (nm >= 0 && ns >= 0) break;
            end
            check($sformatf("R2 main code %0d", V_MCODE[i]), nm, V_MWAIT[i]);
            check($sformatf("R3 sub code %0d", V_SCODE[i]), ns, V_SWAIT[i]);
        end

        // R4: PLL waits 4 edges once the main flag is 1.
        pll_en = 1;
        wait_flag(2, 50, np);
        check("R4 pll wait", np, 4);
        check("R11 status all ready", ready_status, 16'hE000);

        // R6/R7/R8: software and watchdog strobes clear only the PLL flag.
        @(negedge clk); sw_rst_evt = 1;
        @(negedge clk); sw_rst_evt = 0;
        check("R6 main after sw", main_ready, 1);
        check("R7 sub after sw", sub_ready, 1);
        check("R8 pll after sw", pll_ready, 0);
        pll_en = 0;
        @(negedge clk); wdog_rst_evt = 1;
        @(negedge clk); wdog_rst_evt = 0;
        check("R6 main after wdog", main_ready, 1);
        check("R7 sub after wdog", sub_ready, 1);
        @(negedge clk); sclk_stop_evt = 1;
        @(negedge clk); sclk_stop_evt = 0;
        check("R6 main after sub stop", main_ready, 1);
        check("R7 sub after sub stop", sub_ready, 0);
        @(negedge clk); mclk_stop_evt = 1;
        @(negedge clk); mclk_stop_evt = 0;
        check("R6 main after main stop", main_ready, 0);

        // R5: disable then re-enable restarts the full wait.
        main_osc_en = 0;
        cycles(1);
        check("R5 main off", main_ready, 0);
        write_sel(0, 3);
        main_osc_en = 1;
        wait_flag(0, 50, nm);
        check("R5 restart wait", nm, 8);
        main_osc_en = 0;
        cycles(1);
        check("R5 main drops", main_ready, 0);

        // R9: strobe mid-wait restarts at the default main length (1024).
        main_osc_en = 1;
        cycles(4);
        check("R9 still waiting", main_ready, 0);
        @(negedge clk); wdog_rst_evt = 1;
        nm = 0;
        forever begin
            @(posedge clk); nm++;
            @(negedge clk); wdog_rst_evt = 0;
            if (main_ready || nm > 1200) break;
        end
        check("R9 default length after strobe", nm, 1025);

        // R10: main kept by its own use, then by PLL use.
        main_sys_use = 1; main_osc_en = 0;
        cycles(5);
        check("R10 main kept by own use", main_ready, 1);
        main_sys_use = 0; pll_sys_use = 1;
        cycles(3);
        check("R10 main kept by pll use", main_ready, 1);
        pll_sys_use = 0;
        cycles(1);
        check("R5 main drops after use ends", main_ready, 0);

        // R10: sub kept by its own use.
        wait_flag(1, 400, ns);
        check("R3 sub ready before keep test", sub_ready, 1);
        sub_sys_use = 1; sub_osc_en = 0;
        cycles(5);
        check("R10 sub kept by use", sub_ready, 1);
        sub_sys_use = 0;
        cycles(1);
        check("R5 sub drops", sub_ready, 0);

        // R4: PLL does not count while the main flag is 0.
        pll_en = 1;
        cycles(20);
        check("R4 pll blocked", pll_ready, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule